// File: doc/BRIEF.md
# SD single-block read sequencer

This block carries out one complete single-block read from an MMC/SD card in 1-bit mode. A pulse on `start_i` makes it send a 48-bit read command token on the CMD line. The token holds the read-single-block index and the 32-bit address from `addr_i`, and it is protected by a CRC7. The block then listens on CMD for the card's 48-bit R1 response and checks it. If the response is valid, the block waits for the data block on DAT. It turns the 512-byte payload into a stream of bytes, then compares the trailing 16-bit CRC and checks the closing end bit.

Each sequence closes with a one-cycle `done_o` pulse. Five error flags tell the sequence's outcome apart: response timeout, bad response, data timeout, data CRC mismatch and framing error. The flags stay valid from that pulse until the next accepted start. The block runs one bit per `clk` on both lines. It expects the card clock to be generated elsewhere and the open-drain CMD line to be resolved outside the block.

Top module: `sd_block_reader`

## Requirements
- R1: After an accepted start, `cmd_oe_o` is high for exactly 48 consecutive cycles. During those cycles `cmd_o` carries the token MSB first: a 0, a 1, the 6-bit index 17 (binary 010001), `addr_i` MSB first, a CRC7 (polynomial x^7+x^3+1, zero seed) over the first 40 bits, and a final 1.
- R2: Once the token is sent, the block looks for the first 0 on `cmd_i` within a 64-cycle window. If no 0 appears in that window, the sequence ends with `rsp_timeout_o` set, and no data phase follows.
- R3: The response is 48 bits starting with that 0. It is accepted only when all of these hold: bit 46 is 0, bits 45:40 equal 17, bits 7:1 equal the CRC7 of bits 47:8, and bit 0 is 1. Any other response ends the sequence with `rsp_err_o` set. Bits 39:8 of the last response appear on `rsp_status_o`.
- R4: After an accepted response, the block waits up to `data_timeout_i` cycles for a 0 start bit on `dat_i`. If none arrives, the sequence ends with `dat_timeout_o` set.
- R5: The 512 payload bytes that follow the start bit are received MSB first. Each byte appears on `byte_o` with `byte_valid_o` high for one cycle, in arrival order.
- R6: The 16 bits after the payload are compared with a CRC16 (polynomial x^16+x^12+x^5+1, zero seed) over the payload only. A mismatch sets `dat_crc_err_o`.
- R7: The bit after the CRC is the end bit. If it is sampled as 0, `dat_frame_err_o` is set.
- R8: `done_o` is high for exactly one cycle at the end of every sequence, whether it succeeded or failed. All error flags hold their values after it until the next accepted start, which clears them.
- R9: `start_i` has no effect while `busy_o` is high: no new token is sent.
- R10: After reset, the outputs are as follows: `cmd_o` is 1; `cmd_oe_o`, `busy_o`, `done_o`, `byte_valid_o` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a read (accepted only while idle) |
| addr_i | input | 32 | Card address placed in the command token |
| data_timeout_i | input | 16 | Cycles to wait for the data start bit |
| cmd_i | input | 1 | CMD line as seen from the card |
| cmd_o | output | 1 | CMD value driven toward the card |
| cmd_oe_o | output | 1 | CMD drive enable |
| dat_i | input | 1 | DAT0 line from the card |
| byte_o | output | 8 | Received payload byte |
| byte_valid_o | output | 1 | `byte_o` valid this cycle |
| rsp_status_o | output | 32 | Status field of the last response |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| rsp_timeout_o | output | 1 | No response start seen |
| rsp_err_o | output | 1 | Response failed its checks |
| dat_timeout_o | output | 1 | No data start bit seen |
| dat_crc_err_o | output | 1 | Payload CRC16 mismatch |
| dat_frame_err_o | output | 1 | End bit sampled as 0 |

## Verification
The bench goes after addresses of all zeros and all ones, and after responses that are wrong in only one place: a single flipped CRC bit, or an index of 18 carrying a correct CRC. A checker that skipped either test would move on to the data phase and report success. It also withholds the response or the data start bit entirely: a broken timeout counter would hang the sequence or end it with the wrong flag. Corrupted payload CRCs and a 0 end bit expose a design that folds the CRC bits into its own CRC or ignores framing. A start pulse in the middle of the payload would show a missing busy guard as a second command token.

// File: rtl/sdrd_pkg.sv
package sdrd_pkg;

    localparam int unsigned TOKEN_BITS = 48;
    localparam logic [5:0]  RD_INDEX   = 6'd17;

    // one serial step of the 7-bit CRC, polynomial x^7 + x^3 + 1
    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        crc7_step = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    // CRC7 over a 40-bit header, MSB first, zero seed
    function automatic logic [6:0] crc7_of(input logic [39:0] v);
        logic [6:0] c;
        c = '0;
        for (int i = 39; i >= 0; i--) c = crc7_step(c, v[i]);
        crc7_of = c;
    endfunction

    // one serial step of the 16-bit CRC, polynomial x^16 + x^12 + x^5 + 1
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = b ^ c[15];
        crc16_step = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    typedef enum logic [1:0] {SQ_IDLE, SQ_CMD, SQ_RSP, SQ_DAT} seq_st_e;

endpackage

// File: rtl/sdrd_cmd_tx.sv
module sdrd_cmd_tx
    import sdrd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [31:0] addr_i,
    output logic        cmd_o,
    output logic        cmd_oe_o,
    output logic        done_o
);
    localparam int unsigned CW = $clog2(TOKEN_BITS);

    typedef struct packed {
        logic                  active;
        logic [CW-1:0]         cnt;
        logic [TOKEN_BITS-1:0] sh;
        logic                  done;
    } tx_s;

    tx_s s_d, s_q;
    logic [39:0] hdr;

    assign hdr = {2'b01, RD_INDEX, addr_i};

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.active) begin
            s_d.sh  = {s_q.sh[TOKEN_BITS-2:0], 1'b1};
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == CW'(TOKEN_BITS - 1)) begin
                s_d.active = 1'b0;
                s_d.done   = 1'b1;
            end
        end else if (start_i) begin
            s_d.active = 1'b1;
            s_d.cnt    = '0;
            s_d.sh     = {hdr, crc7_of(hdr), 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_o    = s_q.active ? s_q.sh[TOKEN_BITS-1] : 1'b1;
    assign cmd_oe_o = s_q.active;
    assign done_o   = s_q.done;

    // R1
    token_start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe_o) |-> !cmd_o);

    // R1
    token_done_after_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cmd_oe_o && $past(cmd_oe_o));

endmodule

// File: rtl/sdrd_rsp_rx.sv
module sdrd_rsp_rx
    import sdrd_pkg::*;
#(
    parameter int unsigned RSP_WAIT = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        cmd_i,
    output logic        done_o,
    output logic        timeout_o,
    output logic        bad_o,
    output logic [31:0] status_o
);
    localparam int unsigned WW = $clog2(RSP_WAIT + 1);
    localparam int unsigned BW = $clog2(TOKEN_BITS);

    typedef enum logic [1:0] {R_IDLE, R_WAIT, R_BITS} rst_e;

    typedef struct packed {
        rst_e                  st;
        logic [WW-1:0]         wcnt;
        logic [BW-1:0]         bcnt;
        logic [TOKEN_BITS-1:0] sh;
        logic                  done;
        logic                  to;
        logic                  bad;
        logic [31:0]           status;
    } rx_s;

    rx_s s_d, s_q;
    logic [TOKEN_BITS-1:0] word;
    logic                  word_ok;

    assign word    = {s_q.sh[TOKEN_BITS-2:0], cmd_i};
    assign word_ok = (word[46] == 1'b0) && (word[45:40] == RD_INDEX)
                  && (word[7:1] == crc7_of(word[47:8])) && word[0];

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            R_IDLE: if (start_i) begin
                s_d.st   = R_WAIT;
                s_d.wcnt = '0;
                s_d.to   = 1'b0;
                s_d.bad  = 1'b0;
            end
            R_WAIT: begin
                if (!cmd_i) begin
                    s_d.st   = R_BITS;
                    s_d.bcnt = BW'(1);
                    s_d.sh   = '0;
                end else if (s_q.wcnt == WW'(RSP_WAIT - 1)) begin
                    s_d.st   = R_IDLE;
                    s_d.to   = 1'b1;
                    s_d.done = 1'b1;
                end else begin
                    s_d.wcnt = s_q.wcnt + 1'b1;
                end
            end
            R_BITS: begin
                s_d.sh   = word;
                s_d.bcnt = s_q.bcnt + 1'b1;
                if (s_q.bcnt == BW'(TOKEN_BITS - 1)) begin
                    s_d.st     = R_IDLE;
                    s_d.done   = 1'b1;
                    s_d.bad    = !word_ok;
                    s_d.status = word[39:8];
                end
            end
            default: s_d.st = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: R_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign done_o    = s_q.done;
    assign timeout_o = s_q.to;
    assign bad_o     = s_q.bad;
    assign status_o  = s_q.status;

    // R2
    rsp_start_no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == R_WAIT && !cmd_i) |=> !done_o);

    // R3
    rsp_flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(timeout_o && bad_o));

endmodule

// File: rtl/sdrd_dat_rx.sv
module sdrd_dat_rx
    import sdrd_pkg::*;
#(
    parameter int unsigned BLOCK_BYTES = 512,
    parameter int unsigned TO_W        = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [TO_W-1:0] limit_i,
    input  logic            dat_i,
    output logic [7:0]      byte_o,
    output logic            byte_valid_o,
    output logic            done_o,
    output logic            timeout_o,
    output logic            crc_err_o,
    output logic            frame_err_o
);
    localparam int unsigned NBITS = BLOCK_BYTES * 8;
    localparam int unsigned BW    = $clog2(NBITS);

    typedef enum logic [2:0] {D_IDLE, D_WAIT, D_PAY, D_CRC, D_END} dst_e;

    typedef struct packed {
        dst_e            st;
        logic [TO_W-1:0] wcnt;
        logic [BW-1:0]   bcnt;
        logic [7:0]      sh;
        logic [15:0]     calc;
        logic [15:0]     rxc;
        logic [7:0]      byte_v;
        logic            bval;
        logic            done;
        logic            to;
        logic            cerr;
        logic            ferr;
    } dr_s;

    dr_s s_d, s_q;
    logic [TO_W:0] wnext;

    assign wnext = {1'b0, s_q.wcnt} + {{TO_W{1'b0}}, 1'b1};

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.bval = 1'b0;
        unique case (s_q.st)
            D_IDLE: if (start_i) begin
                s_d.st   = D_WAIT;
                s_d.wcnt = '0;
                s_d.to   = 1'b0;
                s_d.cerr = 1'b0;
                s_d.ferr = 1'b0;
            end
            D_WAIT: begin
                if (!dat_i) begin
                    s_d.st   = D_PAY;
                    s_d.bcnt = '0;
                    s_d.calc = '0;
                end else if (wnext >= {1'b0, limit_i}) begin
                    s_d.st   = D_IDLE;
                    s_d.to   = 1'b1;
                    s_d.done = 1'b1;
                end else begin
                    s_d.wcnt = wnext[TO_W-1:0];
                end
            end
            D_PAY: begin
                s_d.sh   = {s_q.sh[6:0], dat_i};
                s_d.calc = crc16_step(s_q.calc, dat_i);
                if (s_q.bcnt[2:0] == 3'd7) begin
                    s_d.byte_v = {s_q.sh[6:0], dat_i};
                    s_d.bval   = 1'b1;
                end
                if (s_q.bcnt == BW'(NBITS - 1)) begin
                    s_d.st   = D_CRC;
                    s_d.bcnt = '0;
                end else begin
                    s_d.bcnt = s_q.bcnt + 1'b1;
                end
            end
            D_CRC: begin
                s_d.rxc  = {s_q.rxc[14:0], dat_i};
                s_d.bcnt = s_q.bcnt + 1'b1;
                if (s_q.bcnt == BW'(15)) s_d.st = D_END;
            end
            D_END: begin
                s_d.st   = D_IDLE;
                s_d.ferr = !dat_i;
                s_d.cerr = (s_q.rxc != s_q.calc);
                s_d.done = 1'b1;
            end
            default: s_d.st = D_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: D_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign byte_o       = s_q.byte_v;
    assign byte_valid_o = s_q.bval;
    assign done_o       = s_q.done;
    assign timeout_o    = s_q.to;
    assign crc_err_o    = s_q.cerr;
    assign frame_err_o  = s_q.ferr;

    // R5
    byte_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |=> !byte_valid_o);

    // R5
    no_byte_while_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == D_WAIT) |-> !byte_valid_o);

    // R4
    timeout_excludes_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(timeout_o && (crc_err_o || frame_err_o)));

endmodule

// File: rtl/sd_block_reader.sv
module sd_block_reader
    import sdrd_pkg::*;
#(
    parameter int unsigned BLOCK_BYTES = 512,
    parameter int unsigned RSP_WAIT    = 64,
    parameter int unsigned TO_W        = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [31:0]     addr_i,
    input  logic [TO_W-1:0] data_timeout_i,
    input  logic            cmd_i,
    output logic            cmd_o,
    output logic            cmd_oe_o,
    input  logic            dat_i,
    output logic [7:0]      byte_o,
    output logic            byte_valid_o,
    output logic [31:0]     rsp_status_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            rsp_timeout_o,
    output logic            rsp_err_o,
    output logic            dat_timeout_o,
    output logic            dat_crc_err_o,
    output logic            dat_frame_err_o
);
    typedef struct packed {
        seq_st_e         st;
        logic [TO_W-1:0] limit;
        logic            done;
        logic            rto;
        logic            rerr;
        logic            dto;
        logic            dcrc;
        logic            dfrm;
    } top_s;

    top_s s_d, s_q;

    logic cmd_start, rsp_start, dat_start;
    logic cmd_done, rsp_done, rsp_to, rsp_bad;
    logic dat_done, dat_to, dat_cerr, dat_ferr;

    assign cmd_start = (s_q.st == SQ_IDLE) && start_i;
    assign rsp_start = (s_q.st == SQ_CMD) && cmd_done;
    assign dat_start = (s_q.st == SQ_RSP) && rsp_done && !rsp_to && !rsp_bad;

    sdrd_cmd_tx u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (cmd_start),
        .addr_i   (addr_i),
        .cmd_o    (cmd_o),
        .cmd_oe_o (cmd_oe_o),
        .done_o   (cmd_done)
    );

    sdrd_rsp_rx #(.RSP_WAIT(RSP_WAIT)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (rsp_start),
        .cmd_i     (cmd_i),
        .done_o    (rsp_done),
        .timeout_o (rsp_to),
        .bad_o     (rsp_bad),
        .status_o  (rsp_status_o)
    );

    sdrd_dat_rx #(.BLOCK_BYTES(BLOCK_BYTES), .TO_W(TO_W)) u_dat (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (dat_start),
        .limit_i      (s_q.limit),
        .dat_i        (dat_i),
        .byte_o       (byte_o),
        .byte_valid_o (byte_valid_o),
        .done_o       (dat_done),
        .timeout_o    (dat_to),
        .crc_err_o    (dat_cerr),
        .frame_err_o  (dat_ferr)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: if (start_i) begin
                s_d.st    = SQ_CMD;
                s_d.limit = data_timeout_i;
                s_d.rto   = 1'b0;
                s_d.rerr  = 1'b0;
                s_d.dto   = 1'b0;
                s_d.dcrc  = 1'b0;
                s_d.dfrm  = 1'b0;
            end
            SQ_CMD: if (cmd_done) s_d.st = SQ_RSP;
            SQ_RSP: if (rsp_done) begin
                if (rsp_to || rsp_bad) begin
                    s_d.st   = SQ_IDLE;
                    s_d.rto  = rsp_to;
                    s_d.rerr = rsp_bad;
                    s_d.done = 1'b1;
                end else begin
                    s_d.st = SQ_DAT;
                end
            end
            SQ_DAT: if (dat_done) begin
                s_d.st   = SQ_IDLE;
                s_d.dto  = dat_to;
                s_d.dcrc = dat_cerr;
                s_d.dfrm = dat_ferr;
                s_d.done = 1'b1;
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy_o          = (s_q.st != SQ_IDLE);
    assign done_o          = s_q.done;
    assign rsp_timeout_o   = s_q.rto;
    assign rsp_err_o       = s_q.rerr;
    assign dat_timeout_o   = s_q.dto;
    assign dat_crc_err_o   = s_q.dcrc;
    assign dat_frame_err_o = s_q.dfrm;

    // R8
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    token_only_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe_o) |-> !$past(busy_o));

    // R3
    rsp_fail_skips_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_timeout_o || rsp_err_o) |-> !(dat_timeout_o || dat_crc_err_o || dat_frame_err_o));

    // R5
    bytes_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> busy_o);

endmodule

// File: tb/tb_sd_block_reader.sv
`timescale 1ns/1ps
module tb_sd_block_reader;
    localparam int NB = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic [15:0] data_timeout_i = 16'd40;
    logic        cmd_i = 1'b1;
    logic        dat_i = 1'b1;
    logic        cmd_o, cmd_oe_o, byte_valid_o, busy_o, done_o;
    logic [7:0]  byte_o;
    logic [31:0] rsp_status_o;
    logic        rsp_timeout_o, rsp_err_o, dat_timeout_o, dat_crc_err_o, dat_frame_err_o;

    always #2.5 clk = ~clk;

    sd_block_reader dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .data_timeout_i(data_timeout_i), .cmd_i(cmd_i), .cmd_o(cmd_o),
        .cmd_oe_o(cmd_oe_o), .dat_i(dat_i), .byte_o(byte_o),
        .byte_valid_o(byte_valid_o), .rsp_status_o(rsp_status_o),
        .busy_o(busy_o), .done_o(done_o), .rsp_timeout_o(rsp_timeout_o),
        .rsp_err_o(rsp_err_o), .dat_timeout_o(dat_timeout_o),
        .dat_crc_err_o(dat_crc_err_o), .dat_frame_err_o(dat_frame_err_o)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] pay [NB];
    logic [7:0] got [NB];
    int nbytes = 0;
    int cmd_rises = 0;
    logic oe_prev = 1'b0;

    always @(negedge clk) begin
        if (byte_valid_o) begin
            got[nbytes % NB] = byte_o;
            nbytes++;
        end
        if (cmd_oe_o && !oe_prev) cmd_rises++;
        oe_prev = cmd_oe_o;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc7(input logic [39:0] v);
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'b0001001;
        end
        return c;
    endfunction

    function automatic logic [15:0] ref_crc16();
        logic [15:0] c = '0;
        for (int b = 0; b < NB; b++)
            for (int j = 7; j >= 0; j--) begin
                logic fb = pay[b][j] ^ c[15];
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        return c;
    endfunction

    // rmode: 0 good, 1 silent, 2 bad crc, 3 bad index
    // ddly < 0: no data block; dmode: 0 good, 1 bad crc, 2 end bit 0
    task automatic do_read(input logic [31:0] addr, input int rdly, input int rmode,
                           input int ddly, input int dmode, input int lim, input bit poke);
        logic [47:0] tok, exp_tok, rsp;
        logic [31:0] status;
        logic [5:0]  idx;
        logic [15:0] c16;
        logic [4:0]  flags;
        int base, k, oe_cnt, mism, rises;
        bit data_sent;

        for (int b = 0; b < NB; b++) pay[b] = 8'($urandom);
        status = $urandom;
        base = nbytes;
        data_sent = (rmode == 0) && (ddly >= 0);

        @(negedge clk);
        addr_i = addr; data_timeout_i = 16'(lim); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; addr_i = ~addr;

        k = 0;
        while (!cmd_oe_o && k < 20) begin @(negedge clk); k++; end
        oe_cnt = 0;
        for (int i = 0; i < 48; i++) begin
            tok[47 - i] = cmd_o;
            if (cmd_oe_o) oe_cnt++;
            @(negedge clk);
        end
        chk("R1 drive length", 64'(oe_cnt), 64'd48);
        chk("R1 drive released", 64'(cmd_oe_o), 64'd0);
        exp_tok = {2'b01, 6'd17, addr, ref_crc7({2'b01, 6'd17, addr}), 1'b1};
        chk("R1 token bits", 64'(tok), 64'(exp_tok));

        if (rmode != 1) begin
            idx = (rmode == 3) ? 6'd18 : 6'd17;
            rsp = {2'b00, idx, status, ref_crc7({2'b00, idx, status}), 1'b1};
            if (rmode == 2) rsp[3] = ~rsp[3];
            repeat (rdly) @(negedge clk);
            for (int i = 47; i >= 0; i--) begin
                cmd_i = rsp[i];
                @(negedge clk);
            end
            cmd_i = 1'b1;
        end

        if (data_sent) begin
            repeat (ddly) @(negedge clk);
            dat_i = 1'b0;
            @(negedge clk);
            for (int b = 0; b < NB; b++)
                for (int j = 7; j >= 0; j--) begin
                    dat_i = pay[b][j];
                    start_i = (poke && b == 100 && j == 7);
                    @(negedge clk);
                end
            start_i = 1'b0;
            c16 = ref_crc16();
            if (dmode == 1) c16 = c16 ^ 16'h0100;
            for (int j = 15; j >= 0; j--) begin
                dat_i = c16[j];
                @(negedge clk);
            end
            dat_i = (dmode != 2);
            @(negedge clk);
            dat_i = 1'b1;
        end

        k = 0;
        while (!done_o && k < 400) begin @(negedge clk); k++; end
        chk("R8 done seen", 64'(done_o), 64'd1);
        chk("R2 rsp timeout flag", 64'(rsp_timeout_o), 64'(rmode == 1));
        chk("R3 rsp error flag", 64'(rsp_err_o), 64'(rmode >= 2));
        chk("R4 data timeout flag", 64'(dat_timeout_o), 64'(rmode == 0 && ddly < 0));
        chk("R6 crc flag", 64'(dat_crc_err_o), 64'(data_sent && dmode == 1));
        chk("R7 frame flag", 64'(dat_frame_err_o), 64'(data_sent && dmode == 2));
        if (rmode == 0) chk("R3 status field", 64'(rsp_status_o), 64'(status));
        chk("R5 byte count", 64'(nbytes - base), data_sent ? 64'(NB) : 64'd0);
        if (data_sent) begin
            mism = 0;
            for (int b = 0; b < NB; b++)
                if (got[(base + b) % NB] !== pay[b]) mism++;
            chk("R5 byte values", 64'(mism), 64'd0);
        end
        flags = {rsp_timeout_o, rsp_err_o, dat_timeout_o, dat_crc_err_o, dat_frame_err_o};
        @(negedge clk);
        chk("R8 done single cycle", 64'(done_o), 64'd0);
        chk("R8 flags held", 64'({rsp_timeout_o, rsp_err_o, dat_timeout_o,
                                  dat_crc_err_o, dat_frame_err_o}), 64'(flags));
        if (poke) begin
            rises = cmd_rises;
            repeat (100) @(negedge clk);
            chk("R9 no extra token", 64'(cmd_rises), 64'(rises));
            chk("R9 idle after busy start", 64'(busy_o), 64'd0);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 cmd idle high", 64'(cmd_o), 64'd1);
        chk("R10 outputs quiet", 64'({cmd_oe_o, busy_o, done_o, byte_valid_o}), 64'd0);
        chk("R10 flags clear", 64'({rsp_timeout_o, rsp_err_o, dat_timeout_o,
                                   dat_crc_err_o, dat_frame_err_o}), 64'd0);

        do_read(32'h0000_0000, 3, 0, 3, 0, 40, 0);
        do_read(32'hFFFF_FFFF, 40, 0, 30, 0, 40, 0);
        for (int n = 0; n < 4; n++)
            do_read($urandom, 3 + int'($urandom % 38), 0, 3 + int'($urandom % 28), 0, 40, 0);
        do_read($urandom, 3, 1, -1, 0, 40, 0);       // R2 silent card
        do_read($urandom, 10, 2, -1, 0, 40, 0);      // R3 crc flip
        do_read($urandom, 10, 3, -1, 0, 40, 0);      // R3 wrong index
        do_read($urandom, 5, 0, -1, 0, 50, 0);       // R4 no start bit
        do_read($urandom, 5, 0, 8, 1, 40, 0);        // R6 bad crc
        do_read($urandom, 5, 0, 8, 2, 40, 0);        // R7 end bit low
        do_read($urandom, 5, 0, 8, 0, 40, 1);        // R9 start while busy, R8 flags cleared

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule